// File: doc/BRIEF.md
# Debug-Port Command and Status Controller

This block sits behind a JTAG-style test access port. It receives 8-bit commands through a data register and returns an 8-bit status word. A TAP controller outside the block supplies three single-cycle controls: capture, shift and update. On capture the block loads its live status into the shift register. While shift is high, bits move LSB-first from `tdi_i` towards `tdo_o`. On update the word that was shifted in is decoded and executed. All of this is synchronous to `clk_i`.

Commands have effects that last after the scan ends. They can:

- hold the device in reset, or release that hold;
- start a whole-memory erase;
- allow or block processor fetches and loads to the memory.

The status word is built from live hardware state, not from a stored register. It reports:

- an erase still in progress;
- a memory error that has been latched;
- the code-protect flag and the configuration-ready flag;
- whether device reset is currently active, from any source.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: A capture cycle loads the status word into the 8-bit shift register. `tdo_o` always presents bit 0 of that register. Each shift cycle moves `tdi_i` into bit 7 and every other bit down by one position. So the status leaves LSB-first, and after eight shifts the register holds the new command with its first-shifted bit as bit 0.
- R2: The status word is laid out as follows. Bit 7 is `unprot_i` (1 = not code-protected). Bit 5 is the latched error flag. Bit 3 is `cfg_ready_i`. Bit 2 is the erase-busy flag. Bit 1 is the access-enable state. Bit 0 is the device-reset state. Bits 6 and 4 always read 0.
- R3: An update with code 0xD1 sets the persistent reset request `rst_req_o`, and an update with 0xD0 clears it. The new value is visible in the cycle after the update edge.
- R4: `dev_rst_o` and status bit 0 are 1 whenever the reset request or `ext_rst_i` is 1. Clearing the request does not release device reset while `ext_rst_i` is still high.
- R5: An update with code 0xFC while the block is not busy does two things in the cycle after the update edge. It raises `erase_start_o` for exactly one cycle, and it sets the busy flag. Busy stays 1 until an `erase_done_i` pulse is seen. If `erase_done_i` arrives in the same cycle as the start, the start wins and busy is left at 1.
- R6: An update with 0xFC while busy is 1 is ignored: there is no strobe, and busy is still cleared by `erase_done_i`.
- R7: An update with 0xFE sets `access_en_o` to 1, and an update with 0xFD sets it to 0.
- R8: An `mem_err_i` pulse sets the error flag, and an erase start clears it. If both fall in the same cycle, the error pulse wins and the flag ends at 1.
- R9: Code 0x00, and any code not listed above, changes no state. The only effect of such an update is that the next scan returns the status.
- R10: After reset, `rst_req_o`, busy, error and `erase_start_o` are 0, `access_en_o` is 1, and the shift register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| capture_i | input | 1 | Load the status into the shift register |
| shift_i | input | 1 | Shift one bit towards `tdo_o` |
| update_i | input | 1 | Execute the shifted command |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (shift register bit 0) |
| ext_rst_i | input | 1 | Reset request from another source |
| erase_done_i | input | 1 | Erase completion pulse from the memory controller |
| mem_err_i | input | 1 | Error pulse from the memory controller |
| unprot_i | input | 1 | 1 = device is not code-protected |
| cfg_ready_i | input | 1 | 1 = configuration read and protect state valid |
| rst_req_o | output | 1 | Persistent reset request set by command |
| dev_rst_o | output | 1 | Device reset active (request OR external) |
| erase_start_o | output | 1 | One-cycle erase start strobe |
| access_en_o | output | 1 | Processor access to memory enabled |

## Verification
Two pairs of events can land in the same clock cycle:

- An erase start and a memory error pulse. The bench raises `mem_err_i` in the exact cycle of a 0xFC update. It then expects the strobe, busy at 1, and error bit 5 still at 1 in the next scan.
- An erase command and a completion pulse. The bench issues 0xFC with `erase_done_i` in the same cycle twice. When the block is idle, busy is expected to stay at 1. When the block is busy, busy is expected to clear and no strobe to appear.

Random command mixes, external reset levels and pulse timing are judged against a bench model of the state, and every scan compares the bits read from `tdo_o`.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int unsigned DR_W = 8;
  typedef logic [DR_W-1:0] dr_word_t;

  localparam dr_word_t CMD_NOP     = 8'h00;
  localparam dr_word_t CMD_RST_SET = 8'hD1;
  localparam dr_word_t CMD_RST_CLR = 8'hD0;
  localparam dr_word_t CMD_ERASE   = 8'hFC;
  localparam dr_word_t CMD_ACC_ON  = 8'hFE;
  localparam dr_word_t CMD_ACC_OFF = 8'hFD;

  typedef struct packed {
    logic unprot;
    logic rsv6;
    logic err;
    logic rsv4;
    logic cfg_rdy;
    logic busy;
    logic acc_en;
    logic dev_rst;
  } status_t;
endpackage

// File: rtl/dbg_dr_shift.sv
module dbg_dr_shift #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             tdi_i,
  input  logic [WIDTH-1:0] cap_val_i,
  output logic             tdo_o,
  output logic [WIDTH-1:0] dr_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] dr_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic in_bit;
    if (i == MSB) begin : g_top
      assign in_bit = tdi_i;
    end else begin : g_mid
      assign in_bit = dr_q[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        dr_q[i] <= 1'b0;
      else if (capture_i) dr_q[i] <= cap_val_i[i];
      else if (shift_i)   dr_q[i] <= in_bit;
    end
  end

  assign tdo_o = dr_q[0];
  assign dr_o  = dr_q;
endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
  import dbg_cmd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     update_i,
  input  dr_word_t cmd_i,
  input  logic     erase_done_i,
  input  logic     mem_err_i,
  output logic     rst_req_o,
  output logic     acc_en_o,
  output logic     busy_o,
  output logic     err_o,
  output logic     erase_start_o
);
  logic rst_req_q, acc_en_q, busy_q, err_q, start_q;
  logic do_set, do_clr, do_on, do_off, do_erase;

  always_comb begin
    do_set   = update_i && (cmd_i == CMD_RST_SET);
    do_clr   = update_i && (cmd_i == CMD_RST_CLR);
    do_on    = update_i && (cmd_i == CMD_ACC_ON);
    do_off   = update_i && (cmd_i == CMD_ACC_OFF);
    // erase while busy is dropped
    do_erase = update_i && (cmd_i == CMD_ERASE) && !busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_q <= 1'b0;
      acc_en_q  <= 1'b1;
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      if (do_set)      rst_req_q <= 1'b1;
      else if (do_clr) rst_req_q <= 1'b0;
      if (do_on)       acc_en_q <= 1'b1;
      else if (do_off) acc_en_q <= 1'b0;
      // start beats done in the same cycle
      if (do_erase)          busy_q <= 1'b1;
      else if (erase_done_i) busy_q <= 1'b0;
      // error pulse beats the clear by a start
      if (mem_err_i)     err_q <= 1'b1;
      else if (do_erase) err_q <= 1'b0;
      start_q <= do_erase;
    end
  end

  assign rst_req_o     = rst_req_q;
  assign acc_en_o      = acc_en_q;
  assign busy_o        = busy_q;
  assign err_o         = err_q;
  assign erase_start_o = start_q;
endmodule

// File: rtl/dbg_status_pack.sv
module dbg_status_pack
  import dbg_cmd_pkg::*;
(
  input  logic    unprot_i,
  input  logic    err_i,
  input  logic    cfg_rdy_i,
  input  logic    busy_i,
  input  logic    acc_en_i,
  input  logic    dev_rst_i,
  output status_t status_o
);
  always_comb begin
    status_o         = '0;
    status_o.unprot  = unprot_i;
    status_o.err     = err_i;
    status_o.cfg_rdy = cfg_rdy_i;
    status_o.busy    = busy_i;
    status_o.acc_en  = acc_en_i;
    status_o.dev_rst = dev_rst_i;
  end
endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic tdi_i,
  output logic tdo_o,
  input  logic ext_rst_i,
  input  logic erase_done_i,
  input  logic mem_err_i,
  input  logic unprot_i,
  input  logic cfg_ready_i,
  output logic rst_req_o,
  output logic dev_rst_o,
  output logic erase_start_o,
  output logic access_en_o
);
  dr_word_t dr_w;
  status_t  status_w;
  logic     busy_w, err_w, rst_req_w, acc_en_w, dev_rst_w;

  dbg_dr_shift #(.WIDTH(DR_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .tdi_i     (tdi_i),
    .cap_val_i (status_w),
    .tdo_o     (tdo_o),
    .dr_o      (dr_w)
  );

  dbg_cmd_exec u_exec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .update_i      (update_i),
    .cmd_i         (dr_w),
    .erase_done_i  (erase_done_i),
    .mem_err_i     (mem_err_i),
    .rst_req_o     (rst_req_w),
    .acc_en_o      (acc_en_w),
    .busy_o        (busy_w),
    .err_o         (err_w),
    .erase_start_o (erase_start_o)
  );

  assign dev_rst_w = rst_req_w | ext_rst_i;

  dbg_status_pack u_pack (
    .unprot_i  (unprot_i),
    .err_i     (err_w),
    .cfg_rdy_i (cfg_ready_i),
    .busy_i    (busy_w),
    .acc_en_i  (acc_en_w),
    .dev_rst_i (dev_rst_w),
    .status_o  (status_w)
  );

  assign rst_req_o   = rst_req_w;
  assign dev_rst_o   = dev_rst_w;
  assign access_en_o = acc_en_w;
endmodule

// File: rtl/dbg_cmd_ctrl_chk.sv
module dbg_cmd_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic update_i,
  input logic ext_rst_i,
  input logic mem_err_i,
  input logic rst_req_o,
  input logic dev_rst_o,
  input logic erase_start_o,
  input logic access_en_o,
  input logic busy_w,
  input logic err_w
);
  // R4
  ext_rst_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |-> dev_rst_o);
  // R5
  start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> busy_w);
  // R5
  start_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |=> !erase_start_o);
  // R6
  no_start_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> !$past(busy_w));
  // R3
  req_rise_on_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(update_i));
  // R7
  acc_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(access_en_o));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_err_i |=> err_w);
endmodule

bind dbg_cmd_ctrl dbg_cmd_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .update_i      (update_i),
  .ext_rst_i     (ext_rst_i),
  .mem_err_i     (mem_err_i),
  .rst_req_o     (rst_req_o),
  .dev_rst_o     (dev_rst_o),
  .erase_start_o (erase_start_o),
  .access_en_o   (access_en_o),
  .busy_w        (busy_w),
  .err_w         (err_w)
);

// File: tb/dbg_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_cmd_ctrl_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic capture_i = 0, shift_i = 0, update_i = 0, tdi_i = 0;
  logic ext_rst_i = 0, erase_done_i = 0, mem_err_i = 0, unprot_i = 0, cfg_ready_i = 0;
  logic tdo_o, rst_req_o, dev_rst_o, erase_start_o, access_en_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model
  bit m_req, m_acc, m_busy, m_err;

  always #4 clk_i = ~clk_i;

  dbg_cmd_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture_i), .shift_i(shift_i),
    .update_i(update_i), .tdi_i(tdi_i), .tdo_o(tdo_o), .ext_rst_i(ext_rst_i),
    .erase_done_i(erase_done_i), .mem_err_i(mem_err_i), .unprot_i(unprot_i),
    .cfg_ready_i(cfg_ready_i), .rst_req_o(rst_req_o), .dev_rst_o(dev_rst_o),
    .erase_start_o(erase_start_o), .access_en_o(access_en_o)
  );

  function automatic logic [7:0] exp_status();
    return {unprot_i, 1'b0, m_err, 1'b0, cfg_ready_i, m_busy, m_acc, m_req | ext_rst_i};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic check_levels(input string req);
    check(rst_req_o === m_req, req, rst_req_o, m_req);
    check(dev_rst_o === (m_req | ext_rst_i), {req, "/R4"}, dev_rst_o, m_req | ext_rst_i);
    check(access_en_o === m_acc, req, access_en_o, m_acc);
  endtask

  // full scan: capture, 8 shifts, update; pulses may coincide with update
  task automatic scan(input logic [7:0] cmd, input bit errp, input bit donep, input string req);
    logic [7:0] got;
    logic [7:0] expv;
    bit start;
    expv = exp_status();
    @(negedge clk_i); capture_i = 1;
    @(negedge clk_i); capture_i = 0; shift_i = 1;
    for (int i = 0; i < 8; i++) begin
      got[i] = tdo_o;
      tdi_i = cmd[i];
      @(negedge clk_i);
    end
    shift_i = 0;
    check(got === expv, "R1/R2 status", got, expv);
    update_i = 1; mem_err_i = errp; erase_done_i = donep;
    @(negedge clk_i);
    update_i = 0; mem_err_i = 0; erase_done_i = 0;
    start = (cmd == 8'hFC) && !m_busy;
    if (cmd == 8'hD1) m_req = 1;
    if (cmd == 8'hD0) m_req = 0;
    if (cmd == 8'hFE) m_acc = 1;
    if (cmd == 8'hFD) m_acc = 0;
    if (start) m_busy = 1; else if (donep) m_busy = 0;
    if (errp) m_err = 1; else if (start) m_err = 0;
    check(erase_start_o === start, {req, " strobe R5/R6"}, erase_start_o, start);
    check_levels(req);
    @(negedge clk_i);
    check(erase_start_o === 1'b0, "R5 strobe width", erase_start_o, 0);
  endtask

  task automatic pulse(input bit donep, input bit errp);
    @(negedge clk_i); erase_done_i = donep; mem_err_i = errp;
    @(negedge clk_i); erase_done_i = 0; mem_err_i = 0;
    if (donep) m_busy = 0;
    if (errp) m_err = 1;
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!finished) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    m_req = 0; m_acc = 1; m_busy = 0; m_err = 0;
    check(tdo_o === 1'b0, "R10 dr", tdo_o, 0);
    check(erase_start_o === 1'b0, "R10 strobe", erase_start_o, 0);
    check_levels("R10");
    rst_ni = 1;
    unprot_i = 1; cfg_ready_i = 1;
    scan(8'h00, 0, 0, "R9 nop");
    // R3 / R4 directed
    scan(8'hD1, 0, 0, "R3 set");
    ext_rst_i = 1;
    scan(8'hD0, 0, 0, "R4 clr while ext");
    check(dev_rst_o === 1'b1, "R4 ext holds", dev_rst_o, 1);
    ext_rst_i = 0;
    scan(8'h00, 0, 0, "R4 released");
    // R7
    scan(8'hFD, 0, 0, "R7 off");
    scan(8'hFE, 0, 0, "R7 on");
    // R5 / R6 / R8
    pulse(0, 1);
    scan(8'hFC, 0, 0, "R5 start clears R8 err");
    scan(8'hFC, 0, 0, "R6 busy ignore");
    scan(8'hFC, 0, 1, "R6 busy with done");
    scan(8'hFC, 1, 0, "R8 err same cycle as start");
    check(m_err && m_busy, "R8 model", m_err, 1);
    pulse(1, 0);
    scan(8'hFC, 0, 1, "R5 start with done");
    pulse(1, 0);
    scan(8'hA5, 0, 0, "R9 unknown");
    scan(8'h00, 0, 0, "R2 read");
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0] cmd;
      int sel;
      sel = $urandom % 8;
      case (sel)
        0: cmd = 8'h00;
        1: cmd = 8'hD1;
        2: cmd = 8'hD0;
        3, 7: cmd = 8'hFC;
        4: cmd = 8'hFE;
        5: cmd = 8'hFD;
        default: cmd = 8'($urandom);
      endcase
      @(negedge clk_i);
      ext_rst_i = (($urandom % 4) == 0);
      unprot_i = 1'($urandom);
      cfg_ready_i = 1'($urandom);
      if (($urandom % 3) == 0) pulse(1'($urandom), 1'($urandom));
      scan(cmd, (($urandom % 8) == 0), (($urandom % 6) == 0), "R1-mix R9");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule